// File: doc/BRIEF.md
# Dual-Clock Shared Memory with Per-Port Width and Write Behaviour

This block is a synchronous memory with two fully independent ports. Each port has its own clock, enable, write strobe, address, data and byte-parity lines, and both ports see the same storage. The default size is 16384 data bits. Ports whose data width is a whole number of bytes also reach a side store of 2048 parity bits, one parity bit per data byte.

Each port has its own parameters for width (1, 2, 4, 8, 16 or 32 data bits) and for write behaviour. The write behaviour sets what the port's read register shows on a write cycle: the word just written, the word the location held before, or the value from the last read, left as it was. A narrow port and a wide port can be mixed. The narrow port's address then picks a slice of the word the wide port sees. This lets the memory act, for example, as a width converter between two clock domains.

Top module: `dpram_dual`

## Requirements
- R1: A port of data width W (1, 2, 4, 8, 16 or 32) has an address of log2(16384/W) bits, and every address from 0 up to the top one is a distinct location.
- R2: On a clock edge with enable and write strobe both high, the data and parity inputs are stored at the addressed location, and a later read of that location returns them.
- R3: On a clock edge with enable high and write strobe low, the addressed contents are loaded into the port's output register and appear on the outputs right after that edge.
- R4: On a clock edge with enable low, the port neither reads nor writes: its outputs keep their value and the memory is not changed, whatever the write strobe, address and data inputs are.
- R5: A port built in write-first mode shows the data and parity being written on its outputs right after the write edge.
- R6: A port built in read-first mode shows the contents the location held before the write on its outputs right after the write edge, while the new value is stored.
- R7: A port built in no-change mode leaves its outputs untouched on write edges, so they keep the value from the last read for as long as writes continue.
- R8: Both ports share one storage. Bit k of the word at address a on a port of width W is storage bit a*W+k. Parity bit k at address a on a port with P = W/8 parity bits is parity bit a*P+k. A value written through one port is read back through the other according to this mapping.
- R9: A port narrower than 8 bits has a one-bit parity output that always reads 0. Its one-bit parity input is ignored.
- R10: At power-up all storage bits and both output registers are 0.
- R11: Activity on one port, including writes, does not change the other port's output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A operation enable |
| we_a | input | 1 | Port A write strobe |
| addr_a | input | log2(DEPTH_BITS/A_WIDTH) | Port A location |
| din_a | input | A_WIDTH | Port A write data |
| pin_a | input | max(1, A_WIDTH/8) | Port A write parity |
| dout_a | output | A_WIDTH | Port A read register, data |
| pout_a | output | max(1, A_WIDTH/8) | Port A read register, parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B operation enable |
| we_b | input | 1 | Port B write strobe |
| addr_b | input | log2(DEPTH_BITS/B_WIDTH) | Port B location |
| din_b | input | B_WIDTH | Port B write data |
| pin_b | input | max(1, B_WIDTH/8) | Port B write parity |
| dout_b | output | B_WIDTH | Port B read register, data |
| pout_b | output | max(1, B_WIDTH/8) | Port B read register, parity |

## Verification
The bench builds two copies of the memory, each at the full 16384-bit size.

The first copy pairs an 8-bit write-first port with a 32-bit read-first port. Sweeping every address on both ports covers byte-to-word lane placement and parity bit placement. It also shows the old contents appearing on the wide port while every word is rewritten.

The second copy pairs a 4-bit no-change port with a 1-bit write-first port. A full bit-by-bit sweep on the 1-bit port reaches every storage bit on its own. The nibble port then shows that its output stays frozen through 4096 consecutive writes, and that its parity output stays at zero.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  // Storage row width: the widest port sees one row per address.
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned PWORD_W = 4;

  // Address bits of a port of width w over a store of depth_bits bits.
  function automatic int unsigned addr_w(int unsigned depth_bits, int unsigned w);
    return $clog2(depth_bits / w);
  endfunction

  // Parity bits carried per access: one per whole data byte.
  function automatic int unsigned par_w(int unsigned w);
    return (w >= 8) ? (w / 8) : 0;
  endfunction

  // Parity pin width at the boundary (never zero).
  function automatic int unsigned par_port_w(int unsigned w);
    return (w >= 8) ? (w / 8) : 1;
  endfunction

  // Ones over w bits of a data row, starting at bit off.
  function automatic logic [WORD_W-1:0] data_field(int unsigned w, logic [4:0] off);
    logic [63:0] ones;
    ones = (64'd1 << w) - 64'd1;
    return WORD_W'(ones) << off;
  endfunction

  // Ones over w bits of a parity row, starting at bit off.
  function automatic logic [PWORD_W-1:0] par_field(int unsigned w, logic [1:0] off);
    logic [7:0] ones;
    ones = (8'd1 << w) - 8'd1;
    return PWORD_W'(ones) << off;
  endfunction

endpackage

// File: rtl/dpram_xorbank.sv
// One write-side bank: written only from its own clock, read combinationally
// by its own port and by the opposite port.
module dpram_xorbank #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned W     = 32,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_bits,
  input  logic [W-1:0]  wr_mask,
  output logic [W-1:0]  rd_bits,
  input  logic [IW-1:0] peek_idx,
  output logic [W-1:0]  peek_bits
);

  logic [W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[wr_idx] <= (cells[wr_idx] & ~wr_mask) | (wr_bits & wr_mask);
  end

  assign rd_bits   = cells[wr_idx];
  assign peek_bits = cells[peek_idx];

endmodule

// File: rtl/dpram_port.sv
// One access port: address-to-lane mapping, merge into its own bank,
// and the mode-dependent output register.
module dpram_port
  import dpram_pkg::*;
#(
  parameter int unsigned DEPTH_BITS = 16384,
  parameter int unsigned WIDTH      = 8,
  parameter wmode_e      MODE       = WM_WRITE_FIRST,
  localparam int unsigned WORDS     = DEPTH_BITS / WORD_W,
  localparam int unsigned IW        = $clog2(WORDS),
  localparam int unsigned AW        = addr_w(DEPTH_BITS, WIDTH),
  localparam int unsigned PW        = par_w(WIDTH),
  localparam int unsigned PPW       = par_port_w(WIDTH)
) (
  input  logic               clk,
  input  logic               en,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [WIDTH-1:0]   din,
  input  logic [PPW-1:0]     pin,
  output logic [WIDTH-1:0]   dout,
  output logic [PPW-1:0]     pout,
  output logic [IW-1:0]      word_idx,
  input  logic [WORD_W-1:0]  far_d,
  input  logic [PWORD_W-1:0] far_p,
  input  logic [IW-1:0]      peek_idx,
  output logic [WORD_W-1:0]  peek_d,
  output logic [PWORD_W-1:0] peek_p
);

  localparam int unsigned LB        = AW - IW;
  localparam logic [4:0]  LANE_MASK = 5'((1 << LB) - 1);

  logic [4:0]         lane;
  logic [4:0]         doff;
  logic [1:0]         poff;
  logic [WORD_W-1:0]  dmask, placed_d, own_d, cur_d;
  logic [PWORD_W-1:0] pmask, placed_p, own_p, cur_p;
  logic [WIDTH-1:0]   rd_field_d;
  logic [PPW-1:0]     rd_field_p, wr_field_p;
  logic               wr_fire;

  // Row select and slice position within the row.
  assign word_idx = IW'(addr >> LB);
  assign lane     = 5'(addr) & LANE_MASK;
  assign doff     = 5'(lane * WIDTH);
  assign poff     = 2'(lane * PW);
  assign dmask    = data_field(WIDTH, doff);
  assign pmask    = par_field(PW, poff);

  assign placed_d = WORD_W'(din) << doff;
  assign placed_p = PWORD_W'(pin) << poff;
  assign wr_fire  = en & we;

  // Logical contents are the XOR of this port's bank and the far bank.
  assign cur_d = own_d ^ far_d;
  assign cur_p = own_p ^ far_p;

  dpram_xorbank #(.DEPTH(WORDS), .W(WORD_W)) u_dbank (
    .clk      (clk),
    .we       (wr_fire),
    .wr_idx   (word_idx),
    .wr_bits  (placed_d ^ far_d),
    .wr_mask  (dmask),
    .rd_bits  (own_d),
    .peek_idx (peek_idx),
    .peek_bits(peek_d)
  );

  dpram_xorbank #(.DEPTH(WORDS), .W(PWORD_W)) u_pbank (
    .clk      (clk),
    .we       (wr_fire),
    .wr_idx   (word_idx),
    .wr_bits  (placed_p ^ far_p),
    .wr_mask  (pmask),
    .rd_bits  (own_p),
    .peek_idx (peek_idx),
    .peek_bits(peek_p)
  );

  assign rd_field_d = WIDTH'(cur_d >> doff);
  assign rd_field_p = (PW == 0) ? '0 : PPW'(cur_p >> poff);
  assign wr_field_p = (PW == 0) ? '0 : pin;

  logic [WIDTH-1:0] dq = '0;
  logic [PPW-1:0]   pq = '0;

  always_ff @(posedge clk) begin
    if (en) begin
      if (!we) begin
        dq <= rd_field_d;
        pq <= rd_field_p;
      end else if (MODE == WM_WRITE_FIRST) begin
        dq <= din;
        pq <= wr_field_p;
      end else if (MODE == WM_READ_FIRST) begin
        dq <= rd_field_d;
        pq <= rd_field_p;
      end
    end
  end

  assign dout = dq;
  assign pout = pq;

endmodule

// File: rtl/dpram_dual.sv
module dpram_dual
  import dpram_pkg::*;
#(
  parameter int unsigned DEPTH_BITS = 16384,
  parameter int unsigned A_WIDTH    = 8,
  parameter wmode_e      A_MODE     = WM_WRITE_FIRST,
  parameter int unsigned B_WIDTH    = 32,
  parameter wmode_e      B_MODE     = WM_READ_FIRST,
  localparam int unsigned IW        = $clog2(DEPTH_BITS / WORD_W),
  localparam int unsigned AAW       = addr_w(DEPTH_BITS, A_WIDTH),
  localparam int unsigned BAW       = addr_w(DEPTH_BITS, B_WIDTH),
  localparam int unsigned APW       = par_port_w(A_WIDTH),
  localparam int unsigned BPW       = par_port_w(B_WIDTH)
) (
  input  logic               clk_a,
  input  logic               en_a,
  input  logic               we_a,
  input  logic [AAW-1:0]     addr_a,
  input  logic [A_WIDTH-1:0] din_a,
  input  logic [APW-1:0]     pin_a,
  output logic [A_WIDTH-1:0] dout_a,
  output logic [APW-1:0]     pout_a,
  input  logic               clk_b,
  input  logic               en_b,
  input  logic               we_b,
  input  logic [BAW-1:0]     addr_b,
  input  logic [B_WIDTH-1:0] din_b,
  input  logic [BPW-1:0]     pin_b,
  output logic [B_WIDTH-1:0] dout_b,
  output logic [BPW-1:0]     pout_b
);

  logic [IW-1:0]      idx_a, idx_b;
  logic [WORD_W-1:0]  peek_d_a, peek_d_b;
  logic [PWORD_W-1:0] peek_p_a, peek_p_b;

  // Named access events for the checker.
  logic wr_evt_a, wr_evt_b;
  assign wr_evt_a = en_a & we_a;
  assign wr_evt_b = en_b & we_b;

  dpram_port #(.DEPTH_BITS(DEPTH_BITS), .WIDTH(A_WIDTH), .MODE(A_MODE)) u_port_a (
    .clk(clk_a), .en(en_a), .we(we_a), .addr(addr_a), .din(din_a), .pin(pin_a),
    .dout(dout_a), .pout(pout_a), .word_idx(idx_a),
    .far_d(peek_d_b), .far_p(peek_p_b),
    .peek_idx(idx_b), .peek_d(peek_d_a), .peek_p(peek_p_a)
  );

  dpram_port #(.DEPTH_BITS(DEPTH_BITS), .WIDTH(B_WIDTH), .MODE(B_MODE)) u_port_b (
    .clk(clk_b), .en(en_b), .we(we_b), .addr(addr_b), .din(din_b), .pin(pin_b),
    .dout(dout_b), .pout(pout_b), .word_idx(idx_b),
    .far_d(peek_d_a), .far_p(peek_p_a),
    .peek_idx(idx_a), .peek_d(peek_d_b), .peek_p(peek_p_b)
  );

endmodule

// File: rtl/dpram_dual_chk.sv
module dpram_dual_chk
  import dpram_pkg::*;
#(
  parameter int unsigned DEPTH_BITS = 16384,
  parameter int unsigned A_WIDTH    = 8,
  parameter wmode_e      A_MODE     = WM_WRITE_FIRST,
  parameter int unsigned B_WIDTH    = 32,
  parameter wmode_e      B_MODE     = WM_READ_FIRST,
  localparam int unsigned APW       = par_port_w(A_WIDTH),
  localparam int unsigned BPW       = par_port_w(B_WIDTH)
) (
  input logic               clk_a,
  input logic               en_a,
  input logic [A_WIDTH-1:0] din_a,
  input logic [A_WIDTH-1:0] dout_a,
  input logic [APW-1:0]     pout_a,
  input logic               wr_evt_a,
  input logic               clk_b,
  input logic               en_b,
  input logic [B_WIDTH-1:0] din_b,
  input logic [B_WIDTH-1:0] dout_b,
  input logic [BPW-1:0]     pout_b,
  input logic               wr_evt_b
);

  logic armed_a = 1'b0;
  logic armed_b = 1'b0;
  always_ff @(posedge clk_a) armed_a <= 1'b1;
  always_ff @(posedge clk_b) armed_b <= 1'b1;

  AST_IDLE_HOLD_A: assert property (@(posedge clk_a) disable iff (!armed_a)
    !en_a |=> ($stable(dout_a) && $stable(pout_a))); // R4
  AST_IDLE_HOLD_B: assert property (@(posedge clk_b) disable iff (!armed_b)
    !en_b |=> ($stable(dout_b) && $stable(pout_b))); // R4
  AST_WF_ECHO_A: assert property (@(posedge clk_a) disable iff (!armed_a)
    ((A_MODE == WM_WRITE_FIRST) && wr_evt_a) |=> (dout_a == $past(din_a))); // R5
  AST_WF_ECHO_B: assert property (@(posedge clk_b) disable iff (!armed_b)
    ((B_MODE == WM_WRITE_FIRST) && wr_evt_b) |=> (dout_b == $past(din_b))); // R5
  AST_NC_FREEZE_A: assert property (@(posedge clk_a) disable iff (!armed_a)
    ((A_MODE == WM_NO_CHANGE) && wr_evt_a) |=> ($stable(dout_a) && $stable(pout_a))); // R7
  AST_NC_FREEZE_B: assert property (@(posedge clk_b) disable iff (!armed_b)
    ((B_MODE == WM_NO_CHANGE) && wr_evt_b) |=> ($stable(dout_b) && $stable(pout_b))); // R7
  AST_NARROW_PAR_ZERO_A: assert property (@(posedge clk_a) disable iff (!armed_a)
    (A_WIDTH < 8) |-> (pout_a == '0)); // R9
  AST_NARROW_PAR_ZERO_B: assert property (@(posedge clk_b) disable iff (!armed_b)
    (B_WIDTH < 8) |-> (pout_b == '0)); // R9

endmodule

bind dpram_dual dpram_dual_chk #(
  .DEPTH_BITS(DEPTH_BITS), .A_WIDTH(A_WIDTH), .A_MODE(A_MODE),
  .B_WIDTH(B_WIDTH), .B_MODE(B_MODE)
) u_chk (.*);

// File: tb/dpram_dual_test.sv
module dpram_dual_test;
  import dpram_pkg::*;

  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = 14;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  always #(CLK_PERIOD/2)   clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  int n_checks = 0;
  int n_err    = 0;

  // Instance 1: A 8-bit write-first, B 32-bit read-first
  logic        a1_en = 0, a1_we = 0;
  logic [10:0] a1_addr = '0;
  logic [7:0]  a1_din = '0, a1_dout;
  logic        a1_pin = 0, a1_pout;
  logic        b1_en = 0, b1_we = 0;
  logic [8:0]  b1_addr = '0;
  logic [31:0] b1_din = '0, b1_dout;
  logic [3:0]  b1_pin = '0, b1_pout;

  dpram_dual #(.A_WIDTH(8), .A_MODE(WM_WRITE_FIRST), .B_WIDTH(32), .B_MODE(WM_READ_FIRST)) uut (
    .clk_a(clk_a), .en_a(a1_en), .we_a(a1_we), .addr_a(a1_addr), .din_a(a1_din), .pin_a(a1_pin),
    .dout_a(a1_dout), .pout_a(a1_pout),
    .clk_b(clk_b), .en_b(b1_en), .we_b(b1_we), .addr_b(b1_addr), .din_b(b1_din), .pin_b(b1_pin),
    .dout_b(b1_dout), .pout_b(b1_pout)
  );

  // Instance 2: A 4-bit no-change, B 1-bit write-first
  logic        a2_en = 0, a2_we = 0;
  logic [11:0] a2_addr = '0;
  logic [3:0]  a2_din = '0, a2_dout;
  logic        a2_pin = 0, a2_pout;
  logic        b2_en = 0, b2_we = 0;
  logic [13:0] b2_addr = '0;
  logic        b2_din = 0, b2_dout;
  logic        b2_pin = 0, b2_pout;

  dpram_dual #(.A_WIDTH(4), .A_MODE(WM_NO_CHANGE), .B_WIDTH(1), .B_MODE(WM_WRITE_FIRST)) uut2 (
    .clk_a(clk_a), .en_a(a2_en), .we_a(a2_we), .addr_a(a2_addr), .din_a(a2_din), .pin_a(a2_pin),
    .dout_a(a2_dout), .pout_a(a2_pout),
    .clk_b(clk_b), .en_b(b2_en), .we_b(b2_we), .addr_b(b2_addr), .din_b(b2_din), .pin_b(b2_pin),
    .dout_b(b2_dout), .pout_b(b2_pout)
  );

  // Reference storage, one per instance, laid out as flat bit strings.
  logic [31:0] mw [2][512];
  logic [3:0]  mp [2][512];

  function automatic int pbits(int w);
    return (w >= 8) ? w / 8 : 0;
  endfunction

  function automatic logic [35:0] mget(int inst, int w, int a);
    logic [35:0] r;
    r = '0;
    for (int k = 0; k < w; k++) begin
      int b;
      b = a * w + k;
      r[k] = mw[inst][b / 32][b % 32];
    end
    for (int k = 0; k < pbits(w); k++) begin
      int b;
      b = a * pbits(w) + k;
      r[32 + k] = mp[inst][b / 4][b % 4];
    end
    return r;
  endfunction

  task automatic mput(int inst, int w, int a, logic [31:0] d, logic [3:0] p);
    for (int k = 0; k < w; k++) begin
      int b;
      b = a * w + k;
      mw[inst][b / 32][b % 32] = d[k];
    end
    for (int k = 0; k < pbits(w); k++) begin
      int b;
      b = a * pbits(w) + k;
      mp[inst][b / 4][b % 4] = p[k];
    end
  endtask

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Each op: drive at the falling edge, let the rising edge act, sample 1 ns later.
  task automatic op1a(logic en, logic we, int addr, logic [31:0] d, logic [3:0] p, output logic [35:0] got);
    @(negedge clk_a);
    a1_en = en; a1_we = we; a1_addr = 11'(addr); a1_din = d[7:0]; a1_pin = p[0];
    @(posedge clk_a); #1;
    got = {3'b0, a1_pout, 24'b0, a1_dout};
    a1_en = 0; a1_we = 0;
  endtask

  task automatic op1b(logic en, logic we, int addr, logic [31:0] d, logic [3:0] p, output logic [35:0] got);
    @(negedge clk_b);
    b1_en = en; b1_we = we; b1_addr = 9'(addr); b1_din = d; b1_pin = p;
    @(posedge clk_b); #1;
    got = {b1_pout, b1_dout};
    b1_en = 0; b1_we = 0;
  endtask

  task automatic op2a(logic en, logic we, int addr, logic [31:0] d, logic [3:0] p, output logic [35:0] got);
    @(negedge clk_a);
    a2_en = en; a2_we = we; a2_addr = 12'(addr); a2_din = d[3:0]; a2_pin = p[0];
    @(posedge clk_a); #1;
    got = {3'b0, a2_pout, 28'b0, a2_dout};
    a2_en = 0; a2_we = 0;
  endtask

  task automatic op2b(logic en, logic we, int addr, logic [31:0] d, logic [3:0] p, output logic [35:0] got);
    @(negedge clk_b);
    b2_en = en; b2_we = we; b2_addr = 14'(addr); b2_din = d[0]; b2_pin = p[0];
    @(posedge clk_b); #1;
    got = {3'b0, b2_pout, 31'b0, b2_dout};
    b2_en = 0; b2_we = 0;
  endtask

  logic done = 1'b0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [35:0] got, got0, prev;
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 512; j++) begin
        mw[i][j] = '0;
        mp[i][j] = '0;
      end

    repeat (3) @(negedge clk_b);
    // R10: power-up state of all outputs and of storage
    chk("R10", {3'b0, a1_pout, 24'b0, a1_dout}, 36'h0);
    chk("R10", {b1_pout, b1_dout}, 36'h0);
    chk("R10", {3'b0, a2_pout, 28'b0, a2_dout}, 36'h0);
    chk("R10", {3'b0, b2_pout, 31'b0, b2_dout}, 36'h0);
    op1b(1, 0, 300, 0, 0, got);
    chk("R10", got, 36'h0);

    // R5/R1: byte port write-first sweep over all 2048 addresses
    for (int a = 0; a < 2048; a++) begin
      logic [7:0] d;
      logic       p;
      d = 8'((a * 37 + 5) & 255);
      p = 1'((a >> 2) ^ a);
      op1a(1, 1, a, {24'b0, d}, {3'b0, p}, got);
      chk((a == 2047) ? "R1" : "R5", got, {3'b0, p, 24'b0, d});
      mput(0, 8, a, {24'b0, d}, {3'b0, p});
    end

    // R8/R3: word port reads every row built from byte writes
    for (int a = 0; a < 512; a++) begin
      op1b(1, 0, a, 0, 0, got);
      chk("R8", got, mget(0, 32, a));
    end

    // R11: byte port output must not move while the word port works
    prev = {3'b0, a1_pout, 24'b0, a1_dout};

    // R6: read-first word writes return the prior row
    for (int a = 0; a < 512; a++) begin
      logic [31:0] nd;
      logic [3:0]  np;
      nd = (a * 32'h9E3779B1) ^ 32'h0000_1234;
      np = 4'(a * 3);
      op1b(1, 1, a, nd, np, got);
      chk("R6", got, mget(0, 32, a));
      mput(0, 32, a, nd, np);
    end
    chk("R11", {3'b0, a1_pout, 24'b0, a1_dout}, prev);

    op1b(1, 0, 5, 0, 0, got);
    chk("R2", got, mget(0, 32, 5));
    op1b(1, 0, 511, 0, 0, got);
    chk("R1", got, mget(0, 32, 511));

    // R8/R3: byte port reads back word-port data with parity lanes
    for (int a = 0; a < 2048; a += 7) begin
      op1a(1, 0, a, 0, 0, got);
      chk("R8", got, mget(0, 8, a));
    end

    // R4: disabled cycles with write strobe high change nothing
    op1a(1, 0, 9, 0, 0, got);
    prev = got;
    op1a(0, 1, 10, 32'h5A, 4'h1, got);
    chk("R4", got, prev);
    op1a(1, 0, 10, 0, 0, got);
    chk("R4", got, mget(0, 8, 10));
    op1b(1, 0, 2, 0, 0, got);
    prev = got;
    op1b(0, 1, 3, 32'hFFFF_FFFF, 4'hF, got);
    chk("R4", got, prev);
    op1b(0, 0, 4, 0, 0, got);
    chk("R4", got, prev);
    op1b(1, 0, 3, 0, 0, got);
    chk("R4", got, mget(0, 32, 3));

    // R5/R9/R1: single-bit write-first sweep over all 16384 bits
    for (int a = 0; a < 16384; a++) begin
      logic d;
      d = 1'(((a * 7) >> 2) ^ (a >> 5));
      op2b(1, 1, a, {31'b0, d}, 4'hF, got);
      chk((a == 16383) ? "R1" : "R5", got, {35'b0, d});
      mput(1, 1, a, {31'b0, d}, 4'h0);
    end

    // R8/R9: nibble port reads all 4096 locations; parity stays 0
    for (int a = 0; a < 4096; a++) begin
      op2a(1, 0, a, 0, 0, got);
      chk((a % 2 == 0) ? "R8" : "R9", got, mget(1, 4, a));
    end

    // R7: no-change output frozen across 4096 writes
    op2a(1, 0, 100, 0, 0, got0);
    chk("R3", got0, mget(1, 4, 100));
    for (int a = 0; a < 4096; a++) begin
      logic [3:0] nd;
      nd = 4'((a * 5 + 3) & 15);
      op2a(1, 1, a, {28'b0, nd}, 4'h1, got);
      chk("R7", got, got0);
      mput(1, 4, a, {28'b0, nd}, 4'h0);
    end
    op2a(1, 0, 100, 0, 0, got);
    chk("R2", got, mget(1, 4, 100));
    op2a(1, 0, 4095, 0, 0, got);
    chk("R1", got, mget(1, 4, 4095));

    // R8: bit port reads nibble-port data
    for (int a = 0; a < 16384; a += 3) begin
      op2b(1, 0, a, 0, 0, got);
      chk("R8", got, mget(1, 1, a));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule